// File: doc/BRIEF.md
# EDO DRAM Access Sequencer

This block sits between a simple host port and one asynchronous 16-bit EDO DRAM that has two byte lanes. The host raises a request with a 22-bit word address, a direction, write data and two byte enables. The controller then plays out the multiplexed strobe sequence on the DRAM pins. The row half of the address goes out first and the row strobe falls. The column half follows on the same pins, and the per-lane column strobes fall. The controller then releases the strobes and precharges. Writes always use the early-write ordering. Write enable and bus data are set up one clock before any column strobe falls. Reads enable the DRAM output and capture the bus while the strobes are still low.

Each timing interval is a parameter counted in controller clocks. These are the row-to-column delay, the column strobe low time, the minimum row strobe low time and the row precharge time. An external refresh arbiter owns the pins while its grant input is low. The controller starts an access only while that grant is high. One access runs at a time. The host sees a single-cycle acknowledge, and for reads the data arrives on that same cycle.

Top module: `dram_seq_ctrl`

## Requirements
- R1: While the row strobe falls, `dram_a` carries `host_addr[21:10]`. While a column strobe falls, `dram_a[9:0]` carries `host_addr[9:0]` and `dram_a[11:10]` is zero.
- R2: The row strobe falls only while both column strobes are high. A column strobe is low only while the row strobe is low.
- R3: `dram_casl_n` (bits 7..0) falls only when `host_be[0]` is 1, and `dram_cash_n` (bits 15..8) falls only when `host_be[1]` is 1. Both enabled strobes fall on the same clock.
- R4: On a write, `dram_we_n` is low and `dram_dq_oe` is high with `dram_dq_o` equal to the write data for at least one clock before the column strobes fall. The bus stays driven until they rise.
- R5: On a read, `dram_we_n` stays high, `dram_oe_n` is low from before the column strobes fall, and `dram_dq_oe` is never high while `dram_oe_n` is low.
- R6: Read data is sampled from `dram_dq_i` on the last clock that the column strobes are low. A lane whose byte enable is 0 returns zero in `host_rdata`.
- R7: The row strobe falls T_RCD+1 clocks before the column strobes fall. The column strobes stay low exactly T_CAS clocks. The row strobe stays low max(T_RAS, T_RCD+1+T_CAS) clocks.
- R8: The row strobe stays high for at least T_RP clocks between accesses. A request held high through precharge is not taken early.
- R9: An access starts only while `acc_gnt` is 1, and nothing moves on the DRAM pins while it is 0. A grant that drops after the access has started does not abort it.
- R10: Reset, including a reset during an access, puts all strobes, `dram_we_n` and `dram_oe_n` high and `dram_dq_oe` and `host_ack` low. The reset takes effect at once.
- R11: `host_ack` is high for exactly one clock per access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| acc_gnt | input | 1 | Refresh arbiter grant; 1 allows a new access to start |
| host_req | input | 1 | Access request, held until acknowledged |
| host_we | input | 1 | 1 = write, 0 = read |
| host_addr | input | 22 | Word address: row in bits 21..10, column in bits 9..0 |
| host_wdata | input | 16 | Write data |
| host_be | input | 2 | Byte enables: bit 1 = bits 15..8, bit 0 = bits 7..0 |
| host_ack | output | 1 | One-clock completion pulse |
| host_rdata | output | 16 | Read data, valid with `host_ack` |
| dram_a | output | 12 | Multiplexed row/column address |
| dram_ras_n | output | 1 | Row strobe, active low |
| dram_casl_n | output | 1 | Low-lane column strobe, active low |
| dram_cash_n | output | 1 | High-lane column strobe, active low |
| dram_we_n | output | 1 | Write enable, active low |
| dram_oe_n | output | 1 | DRAM output enable, active low |
| dram_dq_o | output | 16 | Data driven toward the DRAM |
| dram_dq_oe | output | 1 | Enable for the controller's bus driver |
| dram_dq_i | input | 16 | Data received from the DRAM bus |

## Verification
The hardest situation to reach is a request that is already waiting while the previous access is still precharging. If the precharge count were short, the next row strobe would fall too early. To get there, the bench loads the next vector's address, data and enables on the same clock the acknowledge is seen, and keeps the request high without a gap. A pin monitor then measures every high and low run of the strobes. The bench also sends reads with one lane disabled while its DRAM model drives filler on that lane, and it drops the grant in the middle of an access.

// File: rtl/dram_seq_pkg.sv
`timescale 1ns/1ps
package dram_seq_pkg;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_ASET  = 3'd1,
    ST_ROW   = 3'd2,
    ST_CSET  = 3'd3,
    ST_COL   = 3'd4,
    ST_RHOLD = 3'd5,
    ST_PRE   = 3'd6
  } seq_state_e;

  function automatic int unsigned max_of(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/dram_seq_timer.sv
`timescale 1ns/1ps
module dram_seq_timer #(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             done
);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (load) begin
      cnt_d = load_val;
    end else if (cnt_q != '0) begin
      cnt_d = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_d;
    end
  end

  assign done = (cnt_q == '0);

endmodule

// File: rtl/dram_seq_fsm.sv
`timescale 1ns/1ps
module dram_seq_fsm import dram_seq_pkg::*; #(
  parameter int T_RCD = 2,
  parameter int T_CAS = 2,
  parameter int T_RAS = 6,
  parameter int T_RP  = 3,
  parameter int CNT_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req,
  input  logic             gnt,
  input  logic             tmr_done,
  output seq_state_e       state_q,
  output seq_state_e       state_d,
  output logic             tmr_load,
  output logic [CNT_W-1:0] tmr_val,
  output logic             ack_q
);

  localparam int RAS_BASE = T_RCD + 1 + T_CAS;
  localparam int HOLD     = (T_RAS > RAS_BASE) ? (T_RAS - RAS_BASE) : 0;

  seq_state_e       col_exit;
  logic [CNT_W-1:0] hold_len;
  logic             ack_d;

  // Parameter picks whether an extra row-hold phase exists after the column strobes
  generate
    if (HOLD > 0) begin : g_hold
      assign col_exit = ST_RHOLD;
      assign hold_len = CNT_W'(HOLD - 1);
    end else begin : g_nohold
      assign col_exit = ST_PRE;
      assign hold_len = '0;
    end
  endgenerate

  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_IDLE:  if (req && gnt) state_d = ST_ASET;
      ST_ASET:  state_d = ST_ROW;
      ST_ROW:   if (tmr_done) state_d = ST_CSET;
      ST_CSET:  state_d = ST_COL;
      ST_COL:   if (tmr_done) state_d = col_exit;
      ST_RHOLD: if (tmr_done) state_d = ST_PRE;
      ST_PRE:   if (tmr_done) state_d = ST_IDLE;
      default:  state_d = ST_IDLE;
    endcase
  end

  always_comb begin
    tmr_load = (state_d != state_q);
    case (state_d)
      ST_ROW:   tmr_val = CNT_W'(T_RCD - 1);
      ST_COL:   tmr_val = CNT_W'(T_CAS - 1);
      ST_RHOLD: tmr_val = hold_len;
      ST_PRE:   tmr_val = CNT_W'(T_RP - 1);
      default:  tmr_val = '0;
    endcase
  end

  assign ack_d = (state_d == ST_PRE) && (state_q != ST_PRE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      ack_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      ack_q   <= ack_d;
    end
  end

  AST_ACK_PULSE: assert property (@(posedge clk) disable iff (!rst_n) ack_q |=> !ack_q); // R11

endmodule

// File: rtl/dram_seq_path.sv
`timescale 1ns/1ps
module dram_seq_path import dram_seq_pkg::*; #(
  parameter int ROW_W  = 12,
  parameter int COL_W  = 10,
  parameter int A_W    = 12,
  parameter int DATA_W = 16,
  parameter int T_RP   = 3,
  parameter int CNT_W  = 3
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  seq_state_e             state_q,
  input  seq_state_e             state_d,
  input  logic                   req_we,
  input  logic [ROW_W+COL_W-1:0] req_addr,
  input  logic [DATA_W-1:0]      req_wdata,
  input  logic [1:0]             req_be,
  output logic [A_W-1:0]         pin_a,
  output logic                   pin_ras_n,
  output logic [1:0]             pin_cas_n,
  output logic                   pin_we_n,
  output logic                   pin_oe_n,
  output logic [DATA_W-1:0]      pin_dq_o,
  output logic                   pin_dq_oe,
  input  logic [DATA_W-1:0]      pin_dq_i,
  output logic [DATA_W-1:0]      rdata
);

  localparam int ADDR_W = ROW_W + COL_W;
  localparam int NLANE  = 2;
  localparam int LANE_W = DATA_W / NLANE;

  logic              accept;
  logic              cap;
  logic              col_ph;
  logic              ras_on;
  logic [ADDR_W-1:0] addr_q;
  logic              we_q;
  logic [NLANE-1:0]  be_q;
  logic [DATA_W-1:0] wdata_q;
  logic [ROW_W-1:0]  row_src;
  logic [A_W-1:0]    a_d, a_q;
  logic              ras_n_q, we_n_q, oe_n_q, dq_oe_q;
  logic [NLANE-1:0]  cas_n_d, cas_n_q;
  logic [DATA_W-1:0] rd_lane;
  logic [DATA_W-1:0] rdata_q;
  logic [CNT_W-1:0]  pre_cnt_q;

  assign accept  = (state_q == ST_IDLE) && (state_d == ST_ASET);
  assign cap     = (state_q == ST_COL) && (state_d != ST_COL);
  assign col_ph  = (state_d == ST_CSET) || (state_d == ST_COL);
  assign ras_on  = (state_d == ST_ROW) || col_ph || (state_d == ST_RHOLD);
  assign row_src = accept ? req_addr[ADDR_W-1:COL_W] : addr_q[ADDR_W-1:COL_W];

  always_comb begin
    a_d = a_q;
    if ((state_d == ST_ASET) || (state_d == ST_ROW)) begin
      a_d = A_W'(row_src);
    end else if (col_ph) begin
      a_d = A_W'(addr_q[COL_W-1:0]);
    end
  end

  generate
    for (genvar gi = 0; gi < NLANE; gi++) begin : g_lane
      assign cas_n_d[gi] = !((state_d == ST_COL) && be_q[gi]);
      assign rd_lane[gi*LANE_W +: LANE_W] = be_q[gi] ? pin_dq_i[gi*LANE_W +: LANE_W] : '0;

      AST_EARLY_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(cas_n_q[gi]) && !we_n_q) |-> (!$past(we_n_q) && $past(dq_oe_q))); // R4
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q  <= '0;
      we_q    <= 1'b0;
      be_q    <= '0;
      wdata_q <= '0;
    end else if (accept) begin
      addr_q  <= req_addr;
      we_q    <= req_we;
      be_q    <= req_be;
      wdata_q <= req_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_q     <= '0;
      ras_n_q <= 1'b1;
      cas_n_q <= '1;
      we_n_q  <= 1'b1;
      oe_n_q  <= 1'b1;
      dq_oe_q <= 1'b0;
    end else begin
      a_q     <= a_d;
      ras_n_q <= !ras_on;
      cas_n_q <= cas_n_d;
      we_n_q  <= !(we_q && col_ph);
      oe_n_q  <= !(!we_q && col_ph);
      dq_oe_q <= we_q && col_ph;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata_q <= '0;
    end else if (cap) begin
      rdata_q <= rd_lane;
    end
  end

  // Cycles the row strobe has been high; reset counts as fully precharged
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_cnt_q <= CNT_W'(T_RP);
    end else if (!ras_n_q) begin
      pre_cnt_q <= '0;
    end else if (pre_cnt_q < CNT_W'(T_RP)) begin
      pre_cnt_q <= pre_cnt_q + 1'b1;
    end
  end

  assign pin_a     = a_q;
  assign pin_ras_n = ras_n_q;
  assign pin_cas_n = cas_n_q;
  assign pin_we_n  = we_n_q;
  assign pin_oe_n  = oe_n_q;
  assign pin_dq_o  = wdata_q;
  assign pin_dq_oe = dq_oe_q;
  assign rdata     = rdata_q;

  AST_RAS_FALL_CAS_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ras_n_q) |-> (&cas_n_q)); // R2
  AST_CAS_UNDER_RAS: assert property (@(posedge clk) disable iff (!rst_n)
    !(&cas_n_q) |-> !ras_n_q); // R2
  AST_OE_NO_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !oe_n_q |-> !dq_oe_q); // R5
  AST_PRECHARGE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ras_n_q) |-> (pre_cnt_q >= CNT_W'(T_RP))); // R8

endmodule

// File: rtl/dram_seq_ctrl.sv
`timescale 1ns/1ps
module dram_seq_ctrl import dram_seq_pkg::*; #(
  parameter int ROW_W  = 12,
  parameter int COL_W  = 10,
  parameter int DATA_W = 16,
  parameter int T_RCD  = 2,
  parameter int T_CAS  = 2,
  parameter int T_RAS  = 6,
  parameter int T_RP   = 3
) (
  input  logic                                  clk,
  input  logic                                  rst_n,
  input  logic                                  acc_gnt,
  input  logic                                  host_req,
  input  logic                                  host_we,
  input  logic [ROW_W+COL_W-1:0]                host_addr,
  input  logic [DATA_W-1:0]                     host_wdata,
  input  logic [1:0]                            host_be,
  output logic                                  host_ack,
  output logic [DATA_W-1:0]                     host_rdata,
  output logic [((ROW_W>COL_W)?ROW_W:COL_W)-1:0] dram_a,
  output logic                                  dram_ras_n,
  output logic                                  dram_casl_n,
  output logic                                  dram_cash_n,
  output logic                                  dram_we_n,
  output logic                                  dram_oe_n,
  output logic [DATA_W-1:0]                     dram_dq_o,
  output logic                                  dram_dq_oe,
  input  logic [DATA_W-1:0]                     dram_dq_i
);

  localparam int A_W   = (ROW_W > COL_W) ? ROW_W : COL_W;
  localparam int MAX_T = int'(max_of(max_of(T_RCD, T_CAS), max_of(T_RAS, T_RP)));
  localparam int CNT_W = $clog2(MAX_T + 1);

  logic [1:0]       rst_sync_q;
  logic             core_rst_n;
  seq_state_e       state_q, state_d;
  logic             tmr_load, tmr_done;
  logic [CNT_W-1:0] tmr_val;
  logic [1:0]       cas_n;

  // Reset asserts at once and releases two clocks later
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync_q <= '0;
    end else begin
      rst_sync_q <= {rst_sync_q[0], 1'b1};
    end
  end
  assign core_rst_n = rst_sync_q[1];

  dram_seq_timer #(.CNT_W(CNT_W)) i_timer (
    .clk      (clk),
    .rst_n    (core_rst_n),
    .load     (tmr_load),
    .load_val (tmr_val),
    .done     (tmr_done)
  );

  dram_seq_fsm #(
    .T_RCD (T_RCD),
    .T_CAS (T_CAS),
    .T_RAS (T_RAS),
    .T_RP  (T_RP),
    .CNT_W (CNT_W)
  ) i_fsm (
    .clk      (clk),
    .rst_n    (core_rst_n),
    .req      (host_req),
    .gnt      (acc_gnt),
    .tmr_done (tmr_done),
    .state_q  (state_q),
    .state_d  (state_d),
    .tmr_load (tmr_load),
    .tmr_val  (tmr_val),
    .ack_q    (host_ack)
  );

  dram_seq_path #(
    .ROW_W  (ROW_W),
    .COL_W  (COL_W),
    .A_W    (A_W),
    .DATA_W (DATA_W),
    .T_RP   (T_RP),
    .CNT_W  (CNT_W)
  ) i_path (
    .clk       (clk),
    .rst_n     (core_rst_n),
    .state_q   (state_q),
    .state_d   (state_d),
    .req_we    (host_we),
    .req_addr  (host_addr),
    .req_wdata (host_wdata),
    .req_be    (host_be),
    .pin_a     (dram_a),
    .pin_ras_n (dram_ras_n),
    .pin_cas_n (cas_n),
    .pin_we_n  (dram_we_n),
    .pin_oe_n  (dram_oe_n),
    .pin_dq_o  (dram_dq_o),
    .pin_dq_oe (dram_dq_oe),
    .pin_dq_i  (dram_dq_i),
    .rdata     (host_rdata)
  );

  assign dram_casl_n = cas_n[0];
  assign dram_cash_n = cas_n[1];

endmodule

// File: tb/test_dram_seq_ctrl.sv
`timescale 1ns/1ps
module test_dram_seq_ctrl;

  localparam int T_RCD  = 2;
  localparam int T_CAS  = 2;
  localparam int T_RAS  = 6;
  localparam int T_RP   = 3;
  localparam int RAS_LO = (T_RAS > T_RCD + 1 + T_CAS) ? T_RAS : (T_RCD + 1 + T_CAS);

  // {we, be[1:0], addr[21:0], wdata[15:0], expected rdata[15:0]}
  localparam logic [56:0] VEC [9] = '{
    {1'b1, 2'b11, 22'h2B4C17, 16'hA1B2, 16'h0000},
    {1'b1, 2'b11, 22'h0003FF, 16'h1357, 16'h0000},
    {1'b1, 2'b01, 22'h3FFC00, 16'hC3D4, 16'h0000},
    {1'b1, 2'b10, 22'h2B4C17, 16'h77EE, 16'h0000},
    {1'b0, 2'b11, 22'h2B4C17, 16'h0000, 16'h77B2},
    {1'b0, 2'b11, 22'h0003FF, 16'h0000, 16'h1357},
    {1'b0, 2'b11, 22'h3FFC00, 16'h0000, 16'h5AD4},
    {1'b0, 2'b10, 22'h0003FF, 16'h0000, 16'h1300},
    {1'b0, 2'b01, 22'h2B4C17, 16'h0000, 16'h00B2}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        acc_gnt = 1'b0;
  logic        host_req = 1'b0;
  logic        host_we = 1'b0;
  logic [21:0] host_addr = '0;
  logic [15:0] host_wdata = '0;
  logic [1:0]  host_be = '0;
  logic        host_ack;
  logic [15:0] host_rdata;
  logic [11:0] dram_a;
  logic        dram_ras_n, dram_casl_n, dram_cash_n, dram_we_n, dram_oe_n;
  logic [15:0] dram_dq_o;
  logic        dram_dq_oe;
  logic [15:0] dram_dq_i = 16'hEEEE;

  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;

  always #2.5 clk = ~clk;

  dram_seq_ctrl i_dram_seq_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .acc_gnt     (acc_gnt),
    .host_req    (host_req),
    .host_we     (host_we),
    .host_addr   (host_addr),
    .host_wdata  (host_wdata),
    .host_be     (host_be),
    .host_ack    (host_ack),
    .host_rdata  (host_rdata),
    .dram_a      (dram_a),
    .dram_ras_n  (dram_ras_n),
    .dram_casl_n (dram_casl_n),
    .dram_cash_n (dram_cash_n),
    .dram_we_n   (dram_we_n),
    .dram_oe_n   (dram_oe_n),
    .dram_dq_o   (dram_dq_o),
    .dram_dq_oe  (dram_dq_oe),
    .dram_dq_i   (dram_dq_i)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // DRAM model and pin monitor
  logic [7:0]  mem_l [int];
  logic [7:0]  mem_h [int];
  logic        mon_en = 1'b0;
  logic        p_ras = 1'b1, p_cas = 1'b0, p_we_n = 1'b1, p_dq_oe = 1'b0, p_ack = 1'b0;
  int          ras_lo = 0, ras_hi = 0, cas_lo = 0, ras_falls = 0, acks = 0;
  logic [11:0] m_row = '0;
  logic [9:0]  m_col = '0;

  always @(negedge clk) begin
    logic cas_any;
    int   key;
    cas_any = !(dram_casl_n && dram_cash_n);
    if (mon_en) begin
      if (!dram_ras_n && p_ras) begin
        chk(ras_hi >= T_RP, "R8 precharge before row strobe", 32'(ras_hi), 32'(T_RP));
        chk(dram_a == host_addr[21:10], "R1 row address", 32'(dram_a), 32'(host_addr[21:10]));
        chk(dram_casl_n && dram_cash_n, "R2 column strobes high at row fall", 32'({dram_cash_n, dram_casl_n}), 32'd3);
        m_row = dram_a;
        ras_falls++;
      end
      if (cas_any && !p_cas) begin
        chk(!dram_ras_n, "R2 column strobe under row strobe", 32'(dram_ras_n), 32'd0);
        chk(ras_lo == T_RCD + 1, "R7 row-to-column delay", 32'(ras_lo), 32'(T_RCD + 1));
        chk(dram_a == {2'b00, host_addr[9:0]}, "R1 column address", 32'(dram_a), 32'(host_addr[9:0]));
        chk({!dram_cash_n, !dram_casl_n} == host_be, "R3 lane strobes", 32'({!dram_cash_n, !dram_casl_n}), 32'(host_be));
        m_col = dram_a[9:0];
        key = int'({m_row, m_col});
        if (host_we) begin
          chk(!p_we_n && p_dq_oe && !dram_we_n, "R4 early write setup", 32'({p_we_n, p_dq_oe, dram_we_n}), 32'b010);
          chk(dram_dq_o == host_wdata, "R4 write data", 32'(dram_dq_o), 32'(host_wdata));
          if (!dram_casl_n) mem_l[key] = dram_dq_o[7:0];
          if (!dram_cash_n) mem_h[key] = dram_dq_o[15:8];
        end else begin
          chk(dram_we_n && !dram_oe_n && !dram_dq_oe, "R5 read control", 32'({dram_we_n, dram_oe_n, dram_dq_oe}), 32'b100);
        end
      end
      if (!cas_any && p_cas) begin
        chk(cas_lo == T_CAS, "R7 column strobe width", 32'(cas_lo), 32'(T_CAS));
        if (host_we) chk(p_dq_oe, "R4 data held until strobe rise", 32'(p_dq_oe), 32'd1);
      end
      if (dram_ras_n && !p_ras) chk(ras_lo == RAS_LO, "R7 row strobe width", 32'(ras_lo), 32'(RAS_LO));
      if (!dram_oe_n && dram_dq_oe) chk(1'b0, "R5 bus contention", 32'd1, 32'd0);
      if (host_ack && p_ack) chk(1'b0, "R11 acknowledge wider than one clock", 32'd2, 32'd1);
      if (host_ack) acks++;
    end
    if (!dram_ras_n) ras_lo = p_ras ? 1 : ras_lo + 1;
    else             ras_hi = p_ras ? ras_hi + 1 : 1;
    if (cas_any)     cas_lo = p_cas ? cas_lo + 1 : 1;
    key = int'({m_row, m_col});
    if (!dram_oe_n && !dram_ras_n) begin
      dram_dq_i[7:0]  = (!dram_casl_n) ? (mem_l.exists(key) ? mem_l[key] : 8'h5A) : 8'hEE;
      dram_dq_i[15:8] = (!dram_cash_n) ? (mem_h.exists(key) ? mem_h[key] : 8'h5A) : 8'hEE;
    end else begin
      dram_dq_i = 16'hEEEE;
    end
    p_ras   = dram_ras_n;
    p_cas   = cas_any;
    p_we_n  = dram_we_n;
    p_dq_oe = dram_dq_oe;
    p_ack   = host_ack;
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc == 20000) begin
      n_chk++;
      n_fail++;
      $display("FAIL R11 watchdog actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end

  task automatic wait_ack(output bit got);
    int n;
    n = 0;
    @(negedge clk);
    while (!host_ack && n < 60) begin
      @(negedge clk);
      n++;
    end
    got = host_ack;
    chk(got, "R11 acknowledge arrives", 32'(got), 32'd1);
  endtask

  initial begin
    bit got;
    int f0, a0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    mon_en = 1'b1;

    // R10: reset state
    chk({dram_ras_n, dram_casl_n, dram_cash_n, dram_we_n, dram_oe_n, dram_dq_oe, host_ack} == 7'b1111100,
        "R10 reset state", 32'({dram_ras_n, dram_casl_n, dram_cash_n, dram_we_n, dram_oe_n, dram_dq_oe, host_ack}), 32'b1111100);

    // Vector table: request held high back to back (R8 precharge stress)
    acc_gnt = 1'b1;
    for (int i = 0; i < 9; i++) begin
      host_req   = 1'b1;
      host_we    = VEC[i][56];
      host_be    = VEC[i][55:54];
      host_addr  = VEC[i][53:32];
      host_wdata = VEC[i][31:16];
      wait_ack(got);
      if (got && !VEC[i][56])
        chk(host_rdata == VEC[i][15:0], "R6 read data", 32'(host_rdata), 32'(VEC[i][15:0]));
    end
    host_req = 1'b0;
    repeat (6) @(negedge clk);

    // R9: grant low blocks the start; a grant drop mid-access does not abort
    acc_gnt    = 1'b0;
    host_req   = 1'b1;
    host_we    = 1'b0;
    host_be    = 2'b11;
    host_addr  = 22'h0003FF;
    f0 = ras_falls;
    a0 = acks;
    repeat (12) @(negedge clk);
    chk(ras_falls == f0 && acks == a0 && dram_ras_n, "R9 grant low holds pins", 32'(ras_falls - f0), 32'd0);
    acc_gnt = 1'b1;
    for (int n = 0; n < 20 && dram_ras_n; n++) @(negedge clk);
    acc_gnt = 1'b0;
    wait_ack(got);
    chk(host_rdata == 16'h1357, "R9 access completes after grant drop", 32'(host_rdata), 32'h1357);
    host_req = 1'b0;
    repeat (6) @(negedge clk);

    // R10: reset in the middle of a write, before the column strobes fall
    acc_gnt    = 1'b1;
    host_req   = 1'b1;
    host_we    = 1'b1;
    host_be    = 2'b11;
    host_addr  = 22'h2B4C17;
    host_wdata = 16'hFFFF;
    for (int n = 0; n < 20 && dram_ras_n; n++) @(negedge clk);
    mon_en = 1'b0;
    rst_n  = 1'b0;
    #1;
    chk({dram_ras_n, dram_casl_n, dram_cash_n, dram_we_n, dram_dq_oe} == 5'b11110,
        "R10 reset during access", 32'({dram_ras_n, dram_casl_n, dram_cash_n, dram_we_n, dram_dq_oe}), 32'b11110);
    host_req = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    mon_en = 1'b1;
    host_req  = 1'b1;
    host_we   = 1'b0;
    host_be   = 2'b11;
    wait_ack(got);
    chk(host_rdata == 16'h77B2, "R10 aborted write left cell intact", 32'(host_rdata), 32'h77B2);
    host_req = 1'b0;
    repeat (6) @(negedge clk);

    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

endmodule